// File: doc/BRIEF.md
# Host Descriptor Mailbox with Receive and Transmit Rings

The block sits between a host processor and a pair of link engines, one for receive and one for transmit. The two sides share a small set of registers. To hand over a buffer descriptor, the host first sets a request bit and waits for the block to grant ownership. It then fills in the direction, the upper address bits, the length, the extra-byte marker and the low address. Clearing the request commits the descriptor. The block copies it into a 16-slot ring for the chosen direction.

Each link engine sees the head of its ring. When it finishes a buffer, it raises a completion request. When the shared registers are free, the block copies the head descriptor back into them, sets a ready flag and advances that ring's get pointer. A per-direction pending flag then drives an interrupt whenever its enable bit is set. The host acknowledges the completion by writing a clear bit, which frees the shared registers again.

The control machine has four states:
- IDLE: no ownership is held and no completion is shown.
- GRANTED: the host owns the shared fields.
- COMMIT: the descriptor is written into its ring.
- DONE: a completion is shown and waits for the host.

Its transitions are:
- GRANT_TAKE: IDLE to GRANTED, when the request is high.
- RELEASE: GRANTED to COMMIT, when the request falls.
- STORE: COMMIT to IDLE, always.
- POST: IDLE to DONE, when the request is low and an engine with a non-empty ring asks to complete.
- ACK: DONE to IDLE, on the host clear write.

Register map, at word offsets on `host_addr`:
- CTRL (0): bit 0 is the transmit interrupt enable, bit 1 the receive interrupt enable, bit 4 the request.
- SHARED (1): bit 0 is the direction (0 receive, 1 transmit), bit 1 the grant (read only), bits 3:2 address bits 17:16, bit 4 ready (reads the flag; writing 1 acknowledges), bit 7 the extra-byte marker.
- LEN (2): bits 7:0 hold the length in 16-bit words.
- ALO (3): the 16-bit low address.

The head outputs pack a descriptor as {extra, addr[17:16], len[7:0], addr[15:0]}.

Top module: `desc_mailbox`

## Requirements
- R1: After reset all four registers read zero, grant and ready are low, both interrupts are low and neither ring head is valid.
- R2: With the request bit (CTRL bit 4) set, grant low and ready low, the grant bit (SHARED bit 1) reads 1 after the second rising edge counted from the edge that writes the request.
- R3: Writes to the SHARED direction, address and extra-byte fields, to LEN and to ALO are ignored while grant is low; they read back unchanged.
- R4: Clearing the request while granted drops grant after one edge. After the second edge, the descriptor is stored in the ring picked by the SHARED direction bit (0 receive, 1 transmit), and the shared fields read zero.
- R5: Each ring returns descriptors in the order they were committed. A ring whose get and put pointers are equal reports its head as not valid, and a completion request on that ring is never acknowledged.
- R6: Each ring has 16 slots and wraps modulo 16. After 16 commits ahead of the engine the ring reads idle. A 17th commit makes the ring valid again, with the 17th descriptor at its head.
- R7: A completion request on a non-empty ring, while the request bit and ready are low, is acknowledged in the same cycle. After that edge, ready (SHARED bit 4) is 1, SHARED/LEN/ALO hold the head descriptor with its direction, and the ring advances by one. When both engines ask at once, receive goes first.
- R8: A completion request is not acknowledged while the host holds the request or the grant. It is posted once the request is cleared and the commit has finished.
- R9: No grant is issued while ready is set. Writing SHARED with bit 4 set clears ready and the shared fields.
- R10: Each completion sets a sticky pending flag for its direction, which is cleared only by the acknowledge. The interrupt output equals pending AND that direction's enable, so enabling later still raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register word offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational on host_addr) |
| rx_head_valid | output | 1 | Receive ring holds a descriptor |
| rx_head | output | 27 | Receive ring head descriptor |
| rx_done_req | input | 1 | Receive engine asks to complete its head |
| rx_done_ack | output | 1 | Receive completion accepted this cycle |
| tx_head_valid | output | 1 | Transmit ring holds a descriptor |
| tx_head | output | 27 | Transmit ring head descriptor |
| tx_done_req | input | 1 | Transmit engine asks to complete its head |
| tx_done_ack | output | 1 | Transmit completion accepted this cycle |
| rx_irq | output | 1 | Receive completion interrupt |
| tx_irq | output | 1 | Transmit completion interrupt |

## Verification
Each result has its own latency:
- Grant appears two edges after the request write: one edge to latch CTRL and one for GRANTED.
- A released descriptor reaches its ring head two edges after the release write, through RELEASE and then STORE.
- Completion acknowledges are combinational in the request cycle. Ready, the shared fields and the interrupts change at the next edge.

The bench drives and samples only on falling edges and steps the exact number of rising edges before each read. Its ring model and expected register words come from the register map in the requirements.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int LEN_W  = 8;
    localparam int ALO_W  = 16;
    localparam int AHI_W  = 2;
    localparam int NDIR   = 2;
    localparam int DESC_W = 1 + AHI_W + LEN_W + ALO_W;

    typedef struct packed {
        logic             extra;
        logic [AHI_W-1:0] ahi;
        logic [LEN_W-1:0] len;
        logic [ALO_W-1:0] alo;
    } desc_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_GRANTED = 2'd1,
        ST_COMMIT  = 2'd2,
        ST_DONE    = 2'd3
    } mbx_state_e;
endpackage

// File: rtl/mbx_ring.sv
module mbx_ring
    import mbx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push_i,
    input  desc_t push_desc_i,
    input  logic  pop_i,
    output logic  head_valid_o,
    output desc_t head_o
);
    localparam int PW = $clog2(DEPTH);

    desc_t          slot_q [DEPTH];
    logic [PW-1:0]  put_q;
    logic [PW-1:0]  get_q;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            put_q <= '0;
            get_q <= '0;
        end else begin
            if (push_i) put_q <= nxt(put_q);
            if (pop_i)  get_q <= nxt(get_q);
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) slot_q[put_q] <= push_desc_i;
    end

    assign head_valid_o = (put_q != get_q);
    assign head_o       = slot_q[get_q];

    // An engine may only retire a descriptor that exists
    assert_pop_only_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> head_valid_o);

    // A commit that catches the put pointer up to get leaves the ring idle
    assert_wrap_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && nxt(put_q) == get_q) |=> !head_valid_o);

    // A commit into an idle ring makes it valid
    assert_push_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !head_valid_o) |=> head_valid_o);
endmodule

// File: rtl/mbx_fsm.sv
module mbx_fsm
    import mbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       ack_i,
    input  logic       cmp_rx_i,
    input  logic       cmp_tx_i,
    output logic       grant_o,
    output logic       ready_o,
    output logic       push_o,
    output logic       post_o,
    output logic       post_dir_o,
    output logic       rx_ack_o,
    output logic       tx_ack_o
);
    mbx_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i)                      state_d = ST_GRANTED;
                else if (cmp_rx_i || cmp_tx_i)  state_d = ST_DONE;
            end
            ST_GRANTED: if (!req_i) state_d = ST_COMMIT;
            ST_COMMIT:  state_d = ST_IDLE;
            ST_DONE:    if (ack_i)  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        grant_o    = (state_q == ST_GRANTED);
        ready_o    = (state_q == ST_DONE);
        push_o     = (state_q == ST_COMMIT);
        post_o     = (state_q == ST_IDLE) && !req_i && (cmp_rx_i || cmp_tx_i);
        post_dir_o = !cmp_rx_i;
        rx_ack_o   = post_o && cmp_rx_i;
        tx_ack_o   = post_o && !cmp_rx_i;
    end

    assert_grant_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && !req_i) |=> (!grant_o && push_o));

    assert_no_post_while_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack_o || tx_ack_o) |-> (!req_i && !grant_o));

    assert_ready_blocks_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !grant_o);

    assert_one_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_ack_o, tx_ack_o}));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
    import mbx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            post_i,
    input  logic            post_dir_i,
    input  logic            ack_i,
    input  logic [NDIR-1:0] en_i,
    output logic [NDIR-1:0] irq_o
);
    logic [NDIR-1:0] pend_q;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        always_ff @(posedge clk) begin
            if (!rst_n)                                  pend_q[d] <= 1'b0;
            else if (ack_i)                              pend_q[d] <= 1'b0;
            else if (post_i && post_dir_i == d[0])       pend_q[d] <= 1'b1;
        end
        assign irq_o[d] = pend_q[d] & en_i[d];

        assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_o[d] && !ack_i) |=> (irq_o[d] || !en_i[d]));
    end
endmodule

// File: rtl/desc_mailbox.sv
module desc_mailbox
    import mbx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic [1:0]          host_addr,
    input  logic [15:0]         host_wdata,
    output logic [15:0]         host_rdata,
    output logic                rx_head_valid,
    output logic [DESC_W-1:0]   rx_head,
    input  logic                rx_done_req,
    output logic                rx_done_ack,
    output logic                tx_head_valid,
    output logic [DESC_W-1:0]   tx_head,
    input  logic                tx_done_req,
    output logic                tx_done_ack,
    output logic                rx_irq,
    output logic                tx_irq
);
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_SHRD = 2'd1;
    localparam logic [1:0] A_LEN  = 2'd2;
    localparam logic [1:0] A_ALO  = 2'd3;

    logic             en_tx_q, en_rx_q, req_q;
    logic             sh_dir_q, sh_extra_q;
    logic [AHI_W-1:0] sh_ahi_q;
    logic [LEN_W-1:0] sh_len_q;
    logic [ALO_W-1:0] sh_alo_q;

    logic grant, ready, push, post, post_dir, ack;
    logic [NDIR-1:0] head_v, ring_push, ring_pop, irq_v;
    desc_t           head_d [NDIR];
    desc_t           cur_desc, post_desc;

    assign ack = host_wr && (host_addr == A_SHRD) && host_wdata[4] && ready;

    mbx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_q),
        .ack_i      (ack),
        .cmp_rx_i   (rx_done_req && head_v[0]),
        .cmp_tx_i   (tx_done_req && head_v[1]),
        .grant_o    (grant),
        .ready_o    (ready),
        .push_o     (push),
        .post_o     (post),
        .post_dir_o (post_dir),
        .rx_ack_o   (rx_done_ack),
        .tx_ack_o   (tx_done_ack)
    );

    assign cur_desc = '{extra: sh_extra_q, ahi: sh_ahi_q, len: sh_len_q, alo: sh_alo_q};

    for (genvar d = 0; d < NDIR; d++) begin : g_ring
        assign ring_push[d] = push && (sh_dir_q == d[0]);
        assign ring_pop[d]  = post && (post_dir == d[0]);
        mbx_ring #(.DEPTH(16)) u_ring (
            .clk          (clk),
            .rst_n        (rst_n),
            .push_i       (ring_push[d]),
            .push_desc_i  (cur_desc),
            .pop_i        (ring_pop[d]),
            .head_valid_o (head_v[d]),
            .head_o       (head_d[d])
        );
    end

    assign post_desc = post_dir ? head_d[1] : head_d[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_tx_q <= 1'b0;
            en_rx_q <= 1'b0;
            req_q   <= 1'b0;
        end else if (host_wr && host_addr == A_CTRL) begin
            en_tx_q <= host_wdata[0];
            en_rx_q <= host_wdata[1];
            req_q   <= host_wdata[4];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || push || ack) begin
            sh_dir_q   <= 1'b0;
            sh_extra_q <= 1'b0;
            sh_ahi_q   <= '0;
            sh_len_q   <= '0;
            sh_alo_q   <= '0;
        end else if (post) begin
            sh_dir_q   <= post_dir;
            sh_extra_q <= post_desc.extra;
            sh_ahi_q   <= post_desc.ahi;
            sh_len_q   <= post_desc.len;
            sh_alo_q   <= post_desc.alo;
        end else if (host_wr && grant) begin
            unique case (host_addr)
                A_SHRD: begin
                    sh_dir_q   <= host_wdata[0];
                    sh_ahi_q   <= host_wdata[3:2];
                    sh_extra_q <= host_wdata[7];
                end
                A_LEN:   sh_len_q <= host_wdata[LEN_W-1:0];
                A_ALO:   sh_alo_q <= host_wdata[ALO_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (host_addr)
            A_CTRL:  host_rdata = {11'b0, req_q, 2'b0, en_rx_q, en_tx_q};
            A_SHRD:  host_rdata = {8'b0, sh_extra_q, 2'b0, ready, sh_ahi_q, grant, sh_dir_q};
            A_LEN:   host_rdata = {{(16-LEN_W){1'b0}}, sh_len_q};
            default: host_rdata = sh_alo_q;
        endcase
    end

    mbx_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .post_i     (post),
        .post_dir_i (post_dir),
        .ack_i      (ack),
        .en_i       ({en_tx_q, en_rx_q}),
        .irq_o      (irq_v)
    );

    assign rx_irq        = irq_v[0];
    assign tx_irq        = irq_v[1];
    assign rx_head_valid = head_v[0];
    assign tx_head_valid = head_v[1];
    assign rx_head       = head_d[0];
    assign tx_head       = head_d[1];

    assert_fields_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant && !post && !push && !ack) |=> ($stable(sh_len_q) && $stable(sh_alo_q)));

    assert_ready_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
        post |=> ready);
endmodule

// File: tb/tb_desc_mailbox.sv
`timescale 1ns/1ps
module tb_desc_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        rx_head_valid, tx_head_valid;
    logic [26:0] rx_head, tx_head;
    logic        rx_done_req = 1'b0, tx_done_req = 1'b0;
    logic        rx_done_ack, tx_done_ack;
    logic        rx_irq, tx_irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] en = 2'b00;          // {rx_en, tx_en} as in CTRL bits 1:0

    logic [26:0] mq [2][16];
    int mput [2];
    int mget [2];

    always #2.5 clk = ~clk;

    desc_mailbox dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        step();
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        host_addr = a;
        #0.1;
        d = host_rdata;
    endtask

    function automatic logic [26:0] pack(input logic ex, input logic [1:0] ah,
                                         input logic [7:0] ln, input logic [15:0] al);
        return {ex, ah, ln, al};
    endfunction

    task automatic chk_heads(input string tag);
        chk({tag, " rx valid"}, rx_head_valid, mput[0] != mget[0]);
        chk({tag, " tx valid"}, tx_head_valid, mput[1] != mget[1]);
        if (mput[0] != mget[0]) chk({tag, " rx head"}, rx_head, mq[0][mget[0]]);
        if (mput[1] != mget[1]) chk({tag, " tx head"}, tx_head, mq[1][mget[1]]);
    endtask

    // R2 grant after two edges, R4 commit after two edges
    task automatic t_submit(input logic dir, input logic ex, input logic [1:0] ah,
                            input logic [7:0] ln, input logic [15:0] al);
        logic [15:0] r;
        wr(2'd0, {11'b0, 1'b1, 2'b0, en});
        rd(2'd1, r);
        chk("R2 no grant after one edge", r[1], 1'b0);
        step();
        rd(2'd1, r);
        chk("R2 grant", r[1], 1'b1);
        wr(2'd1, {8'b0, ex, 2'b0, 1'b0, ah, 1'b0, dir});
        wr(2'd2, {8'b0, ln});
        wr(2'd3, al);
        wr(2'd0, {14'b0, en});
        step();
        rd(2'd1, r);
        chk("R4 grant dropped", r[1], 1'b0);
        step();
        mq[dir][mput[dir]] = pack(ex, ah, ln, al);
        mput[dir] = (mput[dir] + 1) % 16;
        rd(2'd2, r);
        chk("R4 fields cleared", r, 16'h0);
        chk_heads("R4 R5 after commit");
    endtask

    // R7 completion of one direction; caller holds the request low
    task automatic t_complete(input logic dir);
        logic [15:0] r;
        logic [26:0] e;
        e = mq[dir][mget[dir]];
        if (dir) tx_done_req = 1'b1; else rx_done_req = 1'b1;
        #0.1;
        chk("R7 ack same cycle", dir ? tx_done_ack : rx_done_ack, 1'b1);
        step();
        rx_done_req = 1'b0; tx_done_req = 1'b0;
        mget[dir] = (mget[dir] + 1) % 16;
        rd(2'd1, r);
        chk("R7 shared word", r, {8'b0, e[26], 2'b0, 1'b1, e[25:24], 1'b0, dir});
        rd(2'd2, r);
        chk("R7 len", r, {8'b0, e[23:16]});
        rd(2'd3, r);
        chk("R7 addr low", r, e[15:0]);
        chk_heads("R7 ring advanced");
        chk("R10 irq", dir ? tx_irq : rx_irq, dir ? en[0] : en[1]);
    endtask

    task automatic t_ack();
        logic [15:0] r;
        wr(2'd1, 16'h0010);
        rd(2'd1, r);
        chk("R9 ack clears ready and fields", r, 16'h0);
        chk("R10 ack clears rx irq", rx_irq, 1'b0);
        chk("R10 ack clears tx irq", tx_irq, 1'b0);
    endtask

    task automatic t_reset();
        logic [15:0] r;
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], r);
            chk("R1 register zero", r, 16'h0);
        end
        chk("R1 rx idle", rx_head_valid, 1'b0);
        chk("R1 tx idle", tx_head_valid, 1'b0);
        chk("R1 irqs", {rx_irq, tx_irq}, 2'b00);
    endtask

    task automatic t_ignore_ungranted();
        logic [15:0] r;
        wr(2'd2, 16'h0005);
        wr(2'd3, 16'h1234);
        wr(2'd1, 16'h008D);
        rd(2'd2, r); chk("R3 len ignored", r, 16'h0);
        rd(2'd3, r); chk("R3 addr ignored", r, 16'h0);
        rd(2'd1, r); chk("R3 shared ignored", r, 16'h0);
    endtask

    task automatic t_late_enable_and_block();
        logic [15:0] r;
        t_complete(1'b0);
        chk("R10 no irq while disabled", rx_irq, 1'b0);
        en = 2'b10;
        wr(2'd0, {14'b0, en});
        chk("R10 late enable fires", rx_irq, 1'b1);
        wr(2'd0, {11'b0, 1'b1, 2'b0, en});
        step(); step(); step();
        rd(2'd1, r);
        chk("R9 no grant while ready", r[1], 1'b0);
        t_ack();
        step();
        rd(2'd1, r);
        chk("R2 grant after ack", r[1], 1'b1);
        wr(2'd0, {14'b0, en});
        step(); step();
        mq[0][mput[0]] = '0;
        mput[0] = (mput[0] + 1) % 16;
        chk_heads("R4 empty commit");
    endtask

    task automatic t_priority();
        rx_done_req = 1'b1; tx_done_req = 1'b1;
        #0.1;
        chk("R7 rx priority rx ack", rx_done_ack, 1'b1);
        chk("R7 rx priority tx ack", tx_done_ack, 1'b0);
        rx_done_req = 1'b0; tx_done_req = 1'b0;
        t_complete(1'b0);
        t_ack();
        en = 2'b11;
        wr(2'd0, {14'b0, en});
        t_complete(1'b1);
        t_ack();
    endtask

    task automatic t_idle_ring();
        logic [15:0] r;
        tx_done_req = 1'b1;
        #0.1;
        chk("R5 idle ring no ack", tx_done_ack, 1'b0);
        step(); step();
        chk("R5 idle ring still no ack", tx_done_ack, 1'b0);
        tx_done_req = 1'b0;
        rd(2'd1, r);
        chk("R5 idle ring no ready", r[4], 1'b0);
    endtask

    task automatic t_defer();
        logic [15:0] r;
        wr(2'd0, {11'b0, 1'b1, 2'b0, en});
        step();
        rx_done_req = 1'b1;
        #0.1;
        chk("R8 no ack while granted", rx_done_ack, 1'b0);
        step(); step();
        chk("R8 still deferred", rx_done_ack, 1'b0);
        rd(2'd1, r);
        chk("R8 no ready while granted", r[4], 1'b0);
        wr(2'd0, {14'b0, en});
        chk("R8 no ack during release", rx_done_ack, 1'b0);
        step();
        mq[0][mput[0]] = '0;
        mput[0] = (mput[0] + 1) % 16;
        step();
        chk("R8 ack after commit", rx_done_ack, 1'b1);
        rx_done_req = 1'b0;
        t_complete(1'b0);
        t_ack();
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 16; i++)
            t_submit(1'b1, i[0], i[1:0], 8'(i + 1), 16'(16'hA000 + i));
        chk("R6 sixteen ahead reads idle", tx_head_valid, 1'b0);
        t_submit(1'b1, 1'b1, 2'd3, 8'h77, 16'hC0DE);
        chk("R6 seventeenth at head", tx_head, pack(1'b1, 2'd3, 8'h77, 16'hC0DE));
        t_complete(1'b1);
        t_ack();
        chk("R6 drained", tx_head_valid, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        mput[0] = 0; mput[1] = 0; mget[0] = 0; mget[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ignore_ungranted();
        t_submit(1'b0, 1'b0, 2'd1, 8'h08, 16'h1000);
        t_submit(1'b0, 1'b1, 2'd2, 8'h03, 16'h2222);
        t_submit(1'b1, 1'b0, 2'd3, 8'h40, 16'hBEEF);
        t_late_enable_and_block();
        t_priority();
        t_idle_ring();
        t_defer();
        t_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule